// File: doc/BRIEF.md
# Sparse Feedforward Neuron Evaluation Unit

This block computes the forward pass of one sparsely connected layer junction. Each cycle it receives a group of weights and the left-layer activations that pair with them. The activations arrive already permuted by an upstream interleaver, so the unit only sees matched pairs. The group holds a whole number of right neurons, so every neuron in the group finishes in the same cycle. For each neuron the unit forms the products, reduces them with an adder tree, adds the neuron's bias and looks up the sigmoid and its derivative in a table. The unit keeps no partial sums between cycles.

All values share one signed fixed-point format. Every multiplier and adder clamps its result to the most positive or most negative code, so no result wraps around. The weight group width and the fan-in are parameters, and the number of neurons finished per cycle is their ratio. Results come out a fixed number of cycles after the group enters. They carry a valid flag and the index of the group's first right neuron. Memory banking, address generation and training control belong to neighbouring blocks.

Top module: `sfn_unit`

## Requirements
- R1: Every value is a 12-bit two's complement number with 8 fractional bits (one LSB = 1/256, range -2048..2047 codes). A product is the full 24-bit product of weight and activation, arithmetically shifted right by 8 (rounding toward minus infinity), then clamped to -2048..2047.
- R2: Each adder (every adder tree node and the bias adder) clamps its sum to 2047 on positive overflow and to -2048 on negative overflow, never wrapping.
- R3: With NPC = PAR/FANIN, slot i of `in_wgt`, `in_act` occupies bits [12i+11:12i]. Neuron g of the group uses weight/activation slots g*FANIN .. g*FANIN+FANIN-1 and bias slot g. Its results appear in slot g of `out_act`/`out_dact`, and its right-neuron index is `out_nidx`+g.
- R4: The adder tree adds adjacent pairs level by level: level one sums products (0,1),(2,3),..., the next level sums adjacent pairs of those sums, and so on up to the root. The bias is added after the root.
- R5: With pre-activation x (a code), the activation for x >= 0 is round(256/(1+e^(-x/256))), rounding halves up. For x < 0 it is 256 minus the value for |x|, with x = -2048 using |x| = 2047. The activation never exceeds 256.
- R6: The derivative output is an unsigned code with 12 fractional bits, equal to round(4096*s*(1-s)) with s the exact sigmoid of |x|/256 (the same |x| rule as R5), so it never exceeds 1024.
- R7: `out_valid` is high exactly 3 clock cycles after a cycle with `in_valid` high, carrying that cycle's `in_nidx`. Data presented while `in_valid` is low produces no output.
- R8: While reset is high, and for the first 3 cycles after it, `out_valid` is low. During reset `out_act` and `out_dact` are zero.
- R9: A new group can enter on every cycle, and back-to-back groups each produce their own result in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Weight group present this cycle |
| in_nidx | input | IDXW | Index of the first right neuron of the group |
| in_wgt | input | PAR*12 | Weights, one 12-bit slot per lane |
| in_act | input | PAR*12 | Left activations paired with the weights |
| in_bias | input | (PAR/FANIN)*12 | One bias per right neuron of the group |
| out_valid | output | 1 | Results present |
| out_nidx | output | IDXW | Index of the first right neuron of the result |
| out_act | output | (PAR/FANIN)*12 | Sigmoid activations, 8 fractional bits |
| out_dact | output | (PAR/FANIN)*12 | Sigmoid derivatives, 12 fractional bits |

## Verification
On every cycle, the assertions check the fixed three-cycle relation between the input and output valid flags and neuron indices, the quiet outputs after reset, and that each activation and derivative stays inside its legal range. The arithmetic itself can only be shown through the bench scenarios. These cover product truncation toward minus infinity, clamping at both ends, the adjacent pairing order of the tree as seen through a bias that sits on a rounding edge, the sigmoid table at its extremes and around zero, the lane-to-slot mapping, and groups arriving back to back or separated by invalid cycles that carry garbage data.

// File: rtl/sfn_pkg.sv
package sfn_pkg;

    localparam int DW    = 12;
    localparam int FRAC  = 8;
    localparam int DFRAC = 12;

    typedef logic signed [DW-1:0] fx_t;

    localparam fx_t FX_MAX = 12'sh7FF;
    localparam fx_t FX_MIN = 12'sh800;

    // one table word: activation code and derivative code for a magnitude
    typedef struct packed {
        logic [DW-1:0] sig;
        logic [DW-1:0] dsig;
    } rom_ent_t;

    // saturating add of two format values
    function automatic fx_t sat_add(input fx_t a, input fx_t b);
        logic signed [DW:0] s;
        s = {a[DW-1], a} + {b[DW-1], b};
        if (s[DW] != s[DW-1])
            return s[DW] ? FX_MIN : FX_MAX;
        return s[DW-1:0];
    endfunction

    // full product, floor shift by FRAC, then clamp
    function automatic fx_t fx_mul(input fx_t a, input fx_t b);
        logic signed [2*DW-1:0] p;
        logic signed [2*DW-1:0] q;
        p = a * b;
        q = p >>> FRAC;
        if (q[2*DW-1:DW-1] != {(DW+1){q[2*DW-1]}})
            return q[2*DW-1] ? FX_MIN : FX_MAX;
        return q[DW-1:0];
    endfunction

    // table contents for a non-negative magnitude code
    function automatic rom_ent_t rom_entry(input int mag);
        real      x;
        real      s;
        int       sv;
        int       dv;
        rom_ent_t e;
        x  = real'(mag) / 256.0;
        s  = 1.0 / (1.0 + $exp(-x));
        sv = $rtoi(s * 256.0 + 0.5);
        dv = $rtoi(s * (1.0 - s) * real'(1 << DFRAC) + 0.5);
        e.sig  = sv[DW-1:0];
        e.dsig = dv[DW-1:0];
        return e;
    endfunction

endpackage

// File: rtl/sfn_adder_tree.sv
module sfn_adder_tree
    import sfn_pkg::*;
#(
    parameter int N = 4
) (
    input  fx_t leaf [N],
    output fx_t sum
);
    localparam int NODES = 2*N - 1;

    // heap layout: node i has children 2i+1 and 2i+2, leaves at the tail
    fx_t node [NODES];

    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign node[N-1+i] = leaf[i];
    end

    for (genvar i = 0; i < N-1; i++) begin : g_node
        assign node[i] = sat_add(node[2*i+1], node[2*i+2]);
    end

    assign sum = node[0];
endmodule

// File: rtl/sfn_neuron.sv
module sfn_neuron
    import sfn_pkg::*;
#(
    parameter int FANIN = 4
) (
    input  fx_t w    [FANIN],
    input  fx_t a    [FANIN],
    input  fx_t bias,
    output fx_t pre
);
    fx_t prod [FANIN];
    fx_t tsum;

    for (genvar i = 0; i < FANIN; i++) begin : g_mul
        assign prod[i] = fx_mul(w[i], a[i]);
    end

    sfn_adder_tree #(.N(FANIN)) u_tree (
        .leaf (prod),
        .sum  (tsum)
    );

    assign pre = sat_add(tsum, bias);
endmodule

// File: rtl/sfn_sigmoid.sv
module sfn_sigmoid
    import sfn_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  fx_t           x,
    output fx_t           act,
    output logic [DW-1:0] dact
);
    localparam int            DEPTH = 1 << (DW-1);
    localparam logic [DW-1:0] ONE   = DW'(1 << FRAC);

    // odd symmetry of the curve: only non-negative magnitudes are stored
    rom_ent_t rom [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++)
            rom[i] = rom_entry(i);
    end

    logic [DW-2:0] mag;
    rom_ent_t      ent_q;
    logic          neg_q;

    always_comb begin
        if (x[DW-1])
            mag = (x == FX_MIN) ? '1 : (DW-1)'(-x);
        else
            mag = x[DW-2:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
            neg_q <= 1'b0;
        end else begin
            ent_q <= rom[mag];
            neg_q <= x[DW-1];
        end
    end

    assign act  = neg_q ? fx_t'(ONE - ent_q.sig) : fx_t'(ent_q.sig);
    assign dact = ent_q.dsig;
endmodule

// File: rtl/sfn_unit.sv
module sfn_unit
    import sfn_pkg::*;
#(
    parameter int PAR   = 8,
    parameter int FANIN = 4,
    parameter int IDXW  = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [IDXW-1:0]             in_nidx,
    input  logic [PAR*DW-1:0]           in_wgt,
    input  logic [PAR*DW-1:0]           in_act,
    input  logic [(PAR/FANIN)*DW-1:0]   in_bias,
    output logic                        out_valid,
    output logic [IDXW-1:0]             out_nidx,
    output logic [(PAR/FANIN)*DW-1:0]   out_act,
    output logic [(PAR/FANIN)*DW-1:0]   out_dact
);
    localparam int NPC = PAR / FANIN;

    typedef struct packed {
        logic            vld;
        logic [IDXW-1:0] nidx;
    } ctl_t;

    ctl_t ctl_s1, ctl_s2, ctl_s3;

    fx_t w_s1   [PAR];
    fx_t a_s1   [PAR];
    fx_t b_s1   [NPC];
    fx_t pre_c  [NPC];
    fx_t pre_s2 [NPC];

    // stage 1: capture the group; stage 2: arithmetic; stage 3: table read
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_s1 <= '0;
            ctl_s2 <= '0;
            ctl_s3 <= '0;
            for (int i = 0; i < PAR; i++) begin
                w_s1[i] <= '0;
                a_s1[i] <= '0;
            end
            for (int g = 0; g < NPC; g++) begin
                b_s1[g]   <= '0;
                pre_s2[g] <= '0;
            end
        end else begin
            ctl_s1 <= '{vld: in_valid, nidx: in_nidx};
            ctl_s2 <= ctl_s1;
            ctl_s3 <= ctl_s2;
            for (int i = 0; i < PAR; i++) begin
                w_s1[i] <= in_wgt[i*DW +: DW];
                a_s1[i] <= in_act[i*DW +: DW];
            end
            for (int g = 0; g < NPC; g++) begin
                b_s1[g]   <= in_bias[g*DW +: DW];
                pre_s2[g] <= pre_c[g];
            end
        end
    end

    for (genvar g = 0; g < NPC; g++) begin : g_nrn
        fx_t           gw [FANIN];
        fx_t           ga [FANIN];
        fx_t           act_g;
        logic [DW-1:0] dact_g;

        for (genvar k = 0; k < FANIN; k++) begin : g_slot
            assign gw[k] = w_s1[g*FANIN + k];
            assign ga[k] = a_s1[g*FANIN + k];
        end

        sfn_neuron #(.FANIN(FANIN)) u_nrn (
            .w    (gw),
            .a    (ga),
            .bias (b_s1[g]),
            .pre  (pre_c[g])
        );

        sfn_sigmoid u_sig (
            .clk  (clk),
            .rst  (rst),
            .x    (pre_s2[g]),
            .act  (act_g),
            .dact (dact_g)
        );

        assign out_act[g*DW +: DW]  = act_g;
        assign out_dact[g*DW +: DW] = dact_g;
    end

    assign out_valid = ctl_s3.vld;
    assign out_nidx  = ctl_s3.nidx;
endmodule

// File: rtl/sfn_unit_chk.sv
module sfn_unit_chk #(
    parameter int PAR   = 8,
    parameter int FANIN = 4,
    parameter int IDXW  = 6
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic [IDXW-1:0]             in_nidx,
    input logic                        out_valid,
    input logic [IDXW-1:0]             out_nidx,
    input logic [(PAR/FANIN)*12-1:0]   out_act,
    input logic [(PAR/FANIN)*12-1:0]   out_dact
);
    localparam int NPC = PAR / FANIN;

    // cycles since reset released, saturating at the pipeline depth
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    // R8
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd3) |-> !out_valid);

    // R7
    lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R7
    lat_index_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid) |-> (out_nidx == $past(in_nidx, 3)));

    for (genvar g = 0; g < NPC; g++) begin : g_lane
        // R5
        act_range_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_act[g*12 +: 12] <= 12'd256));

        // R6
        dact_range_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_dact[g*12 +: 12] <= 12'd1024));
    end
endmodule

bind sfn_unit sfn_unit_chk #(.PAR(PAR), .FANIN(FANIN), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_nidx   (in_nidx),
    .out_valid (out_valid),
    .out_nidx  (out_nidx),
    .out_act   (out_act),
    .out_dact  (out_dact)
);

// File: tb/sfn_unit_test.sv
module sfn_unit_test;
    localparam int PAR   = 8;
    localparam int FANIN = 4;
    localparam int IDXW  = 6;
    localparam int NPC   = PAR / FANIN;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   in_valid;
    logic [IDXW-1:0]        in_nidx;
    logic [PAR*12-1:0]      in_wgt;
    logic [PAR*12-1:0]      in_act;
    logic [NPC*12-1:0]      in_bias;
    logic                   out_valid;
    logic [IDXW-1:0]        out_nidx;
    logic [NPC*12-1:0]      out_act;
    logic [NPC*12-1:0]      out_dact;

    sfn_unit #(.PAR(PAR), .FANIN(FANIN), .IDXW(IDXW)) uut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_nidx (in_nidx),
        .in_wgt (in_wgt), .in_act (in_act), .in_bias (in_bias),
        .out_valid (out_valid), .out_nidx (out_nidx),
        .out_act (out_act), .out_dact (out_dact)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    due;
        string tag;
        int    nidx;
        int    act  [NPC];
        int    dact [NPC];
    } exp_t;

    exp_t q [$];
    int   cyc      = 0;
    int   checks   = 0;
    int   errors   = 0;
    bit   running  = 0;
    bit   reported = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- reference model ----------------
    function automatic int m_sat(input int v);
        if (v > 2047)  return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int m_mul(input int w, input int a);
        int p;
        int f;
        p = w * a;
        f = (p >= 0) ? (p / 256) : -((-p + 255) / 256);
        return m_sat(f);
    endfunction

    function automatic int m_mag(input int x);
        if (x == -2048) return 2047;
        return (x < 0) ? -x : x;
    endfunction

    function automatic real m_s(input int m);
        real x;
        x = real'(m) / 256.0;
        return 1.0 / (1.0 + $exp(-x));
    endfunction

    function automatic int m_act(input int x);
        int v;
        v = $rtoi(m_s(m_mag(x)) * 256.0 + 0.5);
        return (x < 0) ? 256 - v : v;
    endfunction

    function automatic int m_dact(input int x);
        real s;
        s = m_s(m_mag(x));
        return $rtoi(s * (1.0 - s) * 4096.0 + 0.5);
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops the scoreboard when a result is due
    always @(negedge clk) begin
        bit   ev;
        exp_t e;
        if (running && !rst) begin
            ev = (q.size() > 0) && (q[0].due == cyc);
            chk("R7 out_valid timing", int'(out_valid), int'(ev));
            if (ev) begin
                e = q.pop_front();
                chk({e.tag, " R3 out_nidx"}, int'(out_nidx), e.nidx);
                for (int g = 0; g < NPC; g++) begin
                    chk($sformatf("%s act lane %0d", e.tag, g),
                        int'($signed(out_act[g*12 +: 12])), e.act[g]);
                    chk($sformatf("%s dact lane %0d", e.tag, g),
                        int'(out_dact[g*12 +: 12]), e.dact[g]);
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic send(input string tag, input int nidx,
                        input int w [PAR], input int a [PAR], input int b [NPC]);
        exp_t e;
        int   lvl [FANIN];
        int   pre;
        @(negedge clk);
        in_valid = 1'b1;
        in_nidx  = IDXW'(nidx);
        for (int i = 0; i < PAR; i++) begin
            in_wgt[i*12 +: 12] = 12'(w[i]);
            in_act[i*12 +: 12] = 12'(a[i]);
        end
        for (int g = 0; g < NPC; g++) begin
            in_bias[g*12 +: 12] = 12'(b[g]);
            for (int k = 0; k < FANIN; k++)
                lvl[k] = m_mul(w[g*FANIN+k], a[g*FANIN+k]);
            for (int n = FANIN; n > 1; n = n / 2)
                for (int k = 0; k < n/2; k++)
                    lvl[k] = m_sat(lvl[2*k] + lvl[2*k+1]);
            pre       = m_sat(lvl[0] + b[g]);
            e.act[g]  = m_act(pre);
            e.dact[g] = m_dact(pre);
        end
        e.due  = cyc + 3;
        e.tag  = tag;
        e.nidx = nidx;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_nidx  = IDXW'($urandom);
            in_wgt   = {PAR{12'($urandom)}};
            in_act   = {PAR{12'($urandom)}};
            in_bias  = {NPC{12'($urandom)}};
        end
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int w [PAR];
        int a [PAR];
        int b [NPC];
        int xs [10];

        rst = 1'b1; in_valid = 1'b0; in_nidx = '0;
        in_wgt = '0; in_act = '0; in_bias = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 outputs cleared during reset
        chk("R8 reset out_valid", int'(out_valid), 0);
        chk("R8 reset out_act", int'(out_act), 0);
        chk("R8 reset out_dact", int'(out_dact), 0);
        rst = 1'b0;
        running = 1;
        idle(2);

        // R1 basic products: 1.0*0.5 in lane 0, 0.25*-1.0 in lane 1
        foreach (w[i]) begin w[i] = (i < FANIN) ? 256 : 64; a[i] = (i < FANIN) ? 128 : -256; end
        b[0] = 0; b[1] = 100;
        send("R1 basic", 5, w, a, b);
        idle(1);

        // R1 floor shift: four products of -1/256 sum to -4, not 0
        foreach (w[i]) begin w[i] = -1; a[i] = 1; end
        b[0] = 0; b[1] = 0;
        send("R1 floor", 6, w, a, b);

        // R2 positive and negative clamping with bias
        foreach (w[i]) begin w[i] = (i < FANIN) ? 2047 : -2048; a[i] = 2047; end
        b[0] = 2047; b[1] = -2048;
        send("R2 clamp", 7, w, a, b);

        // R4 pairing: products +max,+max,-min,-min give -1; bias 4 sits on a rounding edge
        foreach (w[i]) begin w[i] = ((i % FANIN) < 2) ? 2047 : -2048; a[i] = 2047; end
        b[0] = 4; b[1] = 3;
        send("R4 pairing", 8, w, a, b);
        idle(3);

        // R5 R6 table corners through the bias path
        xs = '{0, 1, -1, 255, -256, 1000, -1000, 2047, -2048, 3};
        for (int t = 0; t < 10; t += 2) begin
            foreach (w[i]) begin w[i] = 0; a[i] = 0; end
            b[0] = xs[t]; b[1] = xs[t+1];
            send("R5 R6 table", t, w, a, b);
        end
        idle(2);

        // R3 lane mapping: one nonzero slot per lane, distinct values
        foreach (w[i]) begin w[i] = 0; a[i] = 0; end
        w[1] = 512; a[1] = 300;
        w[FANIN+2] = -384; a[FANIN+2] = 200;
        b[0] = 0; b[1] = 0;
        send("R3 mapping", 33, w, a, b);
        idle(4);

        // R9 back-to-back random groups, R7 mixed with gaps
        for (int t = 0; t < 40; t++) begin
            foreach (w[i]) begin
                w[i] = int'($urandom_range(4095)) - 2048;
                a[i] = int'($urandom_range(511)) - 256;
            end
            foreach (b[g]) b[g] = int'($urandom_range(1023)) - 512;
            send("R9 stream", t, w, a, b);
            if (t % 13 == 12) idle(2);
        end
        idle(6);

        chk("R7 all results delivered", q.size(), 0);
        report();
    end
endmodule